// File: doc/BRIEF.md
# Two-Level Torus Route Lookup

This block is the route lookup that sits on each input port of a seven-port torus router: one port for injection and ejection at the local processor, plus the six directions ±X, ±Y and ±Z. When a header flit arrives, the block takes its destination field and returns two things: the output port the packet should leave on, and the virtual channel it should use. It does no arithmetic on coordinates. Both answers come straight out of a table entry.

The destination has two parts. The upper three bits name a region and the lower twelve bits name a node inside that region. A region-ID input says which region this router belongs to. If the destination region differs from it, an eight-entry region table steers the packet toward the right region. If the region matches, a 4096-entry node table routes the packet exactly.

Configuration software loads both tables through a single write port. The lookup is registered and takes one cycle. A new header can be accepted on every clock, with no bubbles between them.

Top module: `torus_route_lookup`

## Requirements
- R1: After reset, and in every cycle where `res_valid_o` is low, all four outputs `res_valid_o`, `res_global_o`, `res_port_o` and `res_vc_o` are zero.
- R2: `res_valid_o` is high exactly one clock after a cycle in which `hdr_valid_i` was high, and low one clock after a cycle in which it was low.
- R3: Headers presented on consecutive clocks give results on consecutive clocks. Each result belongs to its own header.
- R4: When `hdr_dest_i[14:12]` equals `region_id_i`, the result is the node-table entry at `hdr_dest_i[11:0]`, and `res_global_o` is 0.
- R5: When `hdr_dest_i[14:12]` differs from `region_id_i`, the result is the region-table entry at `hdr_dest_i[14:12]`, and `res_global_o` is 1.
- R6: A write with `we_i` high works as follows:
  - `tbl_sel_i`=0 writes the node table at `wr_idx_i`.
  - `tbl_sel_i`=1 writes the region table at `wr_idx_i[2:0]`.
  - The entry format is `wr_data_i[3:1]` for the output port and `wr_data_i[0]` for the virtual channel.
- R7: A lookup in the same cycle as a write to the same entry returns the old contents. The new contents are seen from the next lookup on.
- R8: A write has no effect on the other table. With `we_i` low, `wr_data_i` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| region_id_i | input | 3 | Region this router belongs to |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_dest_i | input | 15 | Destination field of the header |
| we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 1 | 0 selects the node table, 1 selects the region table |
| wr_idx_i | input | 12 | Write index |
| wr_data_i | input | 4 | Write data: {port[2:0], vc} |
| res_valid_o | output | 1 | Result valid |
| res_global_o | output | 1 | Result came from the region table |
| res_port_o | output | 3 | Chosen output port |
| res_vc_o | output | 1 | Chosen virtual channel |

## Verification
The bench streams headers back to back across the region boundary, including node indices 0x000 and 0xFFF. A design that mis-slices the destination, or that lags by a cycle, would return the wrong entry or the wrong region flag. It writes an entry in the same cycle as it is looked up, so a design with write-through bypass would return the new value too early. It also writes the region table with an index whose low bits alias a node-table entry, and drives data with write enable low; a design that shared enables would then corrupt the node entry. Finally it changes the region ID, which moves the same destination from the region table to the node table, and confirms that the region-table entry for the router's own region is never used.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int PORT_W  = 3;  // seven router ports
  localparam int VC_W    = 1;
  localparam int ENTRY_W = PORT_W + VC_W;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [VC_W-1:0]   vc;
  } route_entry_t;
endpackage

// File: rtl/route_table.sv
module route_table
  import route_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  route_entry_t     wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output route_entry_t     rd_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  route_entry_t mem_q [DEPTH];

  // Read and write share an edge, so a colliding read returns the old word.
  always_ff @(posedge clk_i) begin
    if (we_i)    mem_q[wr_idx_i] <= wr_data_i;
    if (rd_en_i) rd_data_o       <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/route_hdr_stage.sv
module route_hdr_stage #(
  parameter int REGION_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hdr_valid_i,
  input  logic [REGION_W-1:0] dest_region_i,
  input  logic [REGION_W-1:0] region_id_i,
  output logic                vld_o,
  output logic                remote_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      remote_o <= 1'b0;
    end else begin
      vld_o <= hdr_valid_i;
      if (hdr_valid_i) remote_o <= (dest_region_i != region_id_i);
    end
  end
endmodule

// File: rtl/route_select.sv
module route_select
  import route_pkg::*;
(
  input  logic              vld_i,
  input  logic              remote_i,
  input  route_entry_t      local_i,
  input  route_entry_t      global_i,
  output logic              valid_o,
  output logic              global_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VC_W-1:0]   vc_o
);
  route_entry_t pick;

  always_comb begin
    pick     = remote_i ? global_i : local_i;
    valid_o  = vld_i;
    global_o = vld_i & remote_i;
    port_o   = vld_i ? pick.port : '0;
    vc_o     = vld_i ? pick.vc   : '0;
  end
endmodule

// File: rtl/torus_route_lookup.sv
module torus_route_lookup
  import route_pkg::*;
#(
  parameter int DEST_W      = 15,
  parameter int LOCAL_IDX_W = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEST_W-LOCAL_IDX_W-1:0] region_id_i,
  input  logic                          hdr_valid_i,
  input  logic [DEST_W-1:0]             hdr_dest_i,
  input  logic                          we_i,
  input  logic                          tbl_sel_i,
  input  logic [LOCAL_IDX_W-1:0]        wr_idx_i,
  input  logic [ENTRY_W-1:0]            wr_data_i,
  output logic                          res_valid_o,
  output logic                          res_global_o,
  output logic [PORT_W-1:0]             res_port_o,
  output logic [VC_W-1:0]               res_vc_o
);
  localparam int REGION_W = DEST_W - LOCAL_IDX_W;

  logic [REGION_W-1:0]    dest_region;
  logic [LOCAL_IDX_W-1:0] dest_node;
  logic                   loc_we, glb_we;
  route_entry_t           wr_entry, loc_rd, glb_rd;
  logic                   vld_q, remote_q;

  assign dest_region = hdr_dest_i[DEST_W-1:LOCAL_IDX_W];
  assign dest_node   = hdr_dest_i[LOCAL_IDX_W-1:0];
  assign loc_we      = we_i & ~tbl_sel_i;
  assign glb_we      = we_i &  tbl_sel_i;
  assign wr_entry    = route_entry_t'(wr_data_i);

  route_table #(.IDX_W(LOCAL_IDX_W)) u_local_tbl (
    .clk_i     (clk_i),
    .we_i      (loc_we),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_entry),
    .rd_en_i   (hdr_valid_i),
    .rd_idx_i  (dest_node),
    .rd_data_o (loc_rd)
  );

  route_table #(.IDX_W(REGION_W)) u_global_tbl (
    .clk_i     (clk_i),
    .we_i      (glb_we),
    .wr_idx_i  (wr_idx_i[REGION_W-1:0]),
    .wr_data_i (wr_entry),
    .rd_en_i   (hdr_valid_i),
    .rd_idx_i  (dest_region),
    .rd_data_o (glb_rd)
  );

  route_hdr_stage #(.REGION_W(REGION_W)) u_hdr_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hdr_valid_i   (hdr_valid_i),
    .dest_region_i (dest_region),
    .region_id_i   (region_id_i),
    .vld_o         (vld_q),
    .remote_o      (remote_q)
  );

  route_select u_select (
    .vld_i    (vld_q),
    .remote_i (remote_q),
    .local_i  (loc_rd),
    .global_i (glb_rd),
    .valid_o  (res_valid_o),
    .global_o (res_global_o),
    .port_o   (res_port_o),
    .vc_o     (res_vc_o)
  );
endmodule

// File: rtl/route_lookup_chk.sv
module route_lookup_chk
  import route_pkg::*;
#(
  parameter int DEST_W      = 15,
  parameter int LOCAL_IDX_W = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [DEST_W-LOCAL_IDX_W-1:0] region_id_i,
  input logic                          hdr_valid_i,
  input logic [DEST_W-1:0]             hdr_dest_i,
  input logic                          res_valid_o,
  input logic                          res_global_o,
  input logic [PORT_W-1:0]             res_port_o,
  input logic [VC_W-1:0]               res_vc_o
);
  logic [DEST_W-LOCAL_IDX_W-1:0] dreg;
  assign dreg = hdr_dest_i[DEST_W-1:LOCAL_IDX_W];

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (!res_valid_o && !res_global_o);
  end

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_port_o == '0 && res_vc_o == '0 && !res_global_o));

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> res_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> !res_valid_o);

  a_r4_local_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && dreg == region_id_i) |=> !res_global_o);

  a_r5_remote_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && dreg != region_id_i) |=> res_global_o);
endmodule

bind torus_route_lookup route_lookup_chk #(
  .DEST_W(DEST_W), .LOCAL_IDX_W(LOCAL_IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .region_id_i  (region_id_i),
  .hdr_valid_i  (hdr_valid_i),
  .hdr_dest_i   (hdr_dest_i),
  .res_valid_o  (res_valid_o),
  .res_global_o (res_global_o),
  .res_port_o   (res_port_o),
  .res_vc_o     (res_vc_o)
);

// File: tb/tb_torus_route_lookup.sv
module tb_torus_route_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {dest[14:0], global, port[2:0], vc}; region 3 is local
  localparam logic [19:0] VECS [NVEC] = '{
    {15'h3005, 5'b00101}, {15'h3FFF, 5'b01100},
    {15'h3000, 5'b00001}, {15'h3123, 5'b01000},
    {15'h0005, 5'b10010}, {15'h7123, 5'b11011},
    {15'h0FFF, 5'b10010}, {15'h7000, 5'b11011}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  region_id_i = 3'd3;
  logic        hdr_valid_i = 1'b0;
  logic [14:0] hdr_dest_i = '0;
  logic        we_i = 1'b0;
  logic        tbl_sel_i = 1'b0;
  logic [11:0] wr_idx_i = '0;
  logic [3:0]  wr_data_i = '0;
  logic        res_valid_o, res_global_o;
  logic [2:0]  res_port_o;
  logic [0:0]  res_vc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  torus_route_lookup dut (.*);

  task automatic check(input logic [5:0] exp, input string req);
    logic [5:0] act;
    act = {res_valid_o, res_global_o, res_port_o, res_vc_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [11:0] idx, input logic [3:0] d, input logic en);
    @(negedge clk_i);
    we_i = en; tbl_sel_i = sel; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic look(input logic [14:0] dest, input logic [4:0] exp, input string req);
    @(negedge clk_i);
    hdr_valid_i = 1'b1; hdr_dest_i = dest;
    @(negedge clk_i);
    hdr_valid_i = 1'b0;
    check({1'b1, exp}, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    check(6'b0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(6'b0, "R1 after reset");

    // R6 table load
    wr(1'b0, 12'h005, 4'h5, 1'b1);
    wr(1'b0, 12'hFFF, 4'hC, 1'b1);
    wr(1'b0, 12'h000, 4'h1, 1'b1);
    wr(1'b0, 12'h123, 4'h8, 1'b1);
    wr(1'b1, 12'h000, 4'h2, 1'b1);
    wr(1'b1, 12'h007, 4'hB, 1'b1);
    wr(1'b1, 12'h003, 4'hF, 1'b1);

    // R3/R4/R5 back-to-back walk
    for (int i = 0; i <= NVEC; i++) begin
      @(negedge clk_i);
      if (i > 0) check({1'b1, VECS[i-1][4:0]}, "R3 R4 R5 vector walk");
      if (i < NVEC) begin
        hdr_valid_i = 1'b1; hdr_dest_i = VECS[i][19:5];
      end else hdr_valid_i = 1'b0;
    end
    @(negedge clk_i);
    check(6'b0, "R2 valid drops after idle header");

    // R7 collision: old contents, then new
    @(negedge clk_i);
    we_i = 1'b1; tbl_sel_i = 1'b0; wr_idx_i = 12'h005; wr_data_i = 4'h6;
    hdr_valid_i = 1'b1; hdr_dest_i = 15'h3005;
    @(negedge clk_i);
    we_i = 1'b0; hdr_valid_i = 1'b0;
    check(6'b100101, "R7 read-during-write old");
    look(15'h3005, 5'b00110, "R7 new value visible");

    // R8 region-table write aliasing node index 5
    wr(1'b1, 12'h005, 4'h4, 1'b1);
    look(15'h3005, 5'b00110, "R8 node entry untouched");
    look(15'h5000, 5'b10100, "R6 region entry written");
    wr(1'b0, 12'h123, 4'hE, 1'b0);
    look(15'h3123, 5'b01000, "R8 write with we low ignored");

    // R4/R5 region change
    region_id_i = 3'd7;
    look(15'h7123, 5'b01000, "R4 own region now 7");
    look(15'h3005, 5'b11111, "R5 region 3 via region table");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule